// File: doc/BRIEF.md
# Misaligned Word Access Splitter

This block stands between a load/store requester and a word-wide memory made of four byte lanes. The requester hands over a byte address, an access size of one, two or four bytes, a read/write flag and, for writes, the data. When all requested bytes lie inside one aligned word, the block runs a single memory cycle. When they straddle a word boundary, it runs two word cycles. The first covers the upper lanes of the lower word and the second covers the lower lanes of the following word. Read bytes from both cycles are merged into one right-justified result, and write bytes are steered onto their lanes with a per-lane enable.

A mode input chooses between two treatments of misaligned requests. With faulting enabled, a misaligned request is dropped, memory is left unchanged, and an error pulse is returned instead. With faulting disabled, every request completes, and a boundary-crossing one costs exactly one extra cycle. The memory is a synchronous single-port model, and its row decoder selects exactly one word row per memory cycle.

Top module: `split_access_unit`

## Requirements
- R1: After reset, req_ready is 1 and done and err are both 0.
- R2: An access whose offset (address bits 1:0) plus its byte count is at most 4 uses one memory cycle. done is high for that request starting after the second rising clock edge that follows the edge which accepted it.
- R3: A read of n bytes at byte address a returns the byte stored at a+i in rdata bits 8i+7..8i for each i below n, with all higher result bytes zero. Size codes are 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes.
- R4: A write of n bytes at address a stores req_wdata bits 8i+7..8i at byte address a+i for each i below n. Every other byte of memory keeps its value.
- R5: An access is split into two word cycles exactly when its offset plus its byte count exceeds 4. A split access raises done one edge later than R2, after the third rising edge following acceptance. One-byte accesses never split.
- R6: With trap_en at 1, a two-byte access at an odd address or a four-byte access at a nonzero offset is misaligned. Such an access is not performed. Instead, err is high starting right after the accepting edge, done stays low, and memory is unchanged. Aligned accesses in this mode behave as in R2.
- R7: req_ready is low from the cycle after a performed request is accepted until done rises. A request presented during that time has no effect.
- R8: The second cycle of a split access addresses the next word index, wrapping from the last word of memory to word 0.
- R9: done and err are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| trap_en | input | 1 | 1 selects faulting on misaligned requests, 0 selects split handling |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_wdata | input | 32 | Write data, right-justified |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle misalignment fault pulse |
| rdata | output | 32 | Merged read result, valid with done on reads |

## Verification
A wrong lane enable or steering shift in either cycle shows up at the ports on the next readback of the affected bytes. It appears as a wrong byte in rdata or as a clobbered neighbour in a full byte sweep. A wrong split decision or a stuck state appears at once as done arriving one edge early or late, or never. A faulty misalignment classification shows up in the cycle right after acceptance, as a missing or spurious err pulse. A wrong second-word index appears as wrong upper bytes on reads that cross a boundary, including the wrap at the top of memory.

// File: rtl/sau_pkg.sv
package sau_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC0 = 2'd1,
        ST_ACC1 = 2'd2,
        ST_WRAP = 2'd3
    } sau_state_e;

    typedef struct packed {
        logic       split;
        logic       misal;
        logic [3:0] be_lo;
        logic [3:0] be_hi;
    } lane_plan_t;

    // Lane footprint of an access over two adjacent words, low word in bits 3:0.
    function automatic logic [7:0] lane_span(input logic [1:0] off, input logic [1:0] sz);
        logic [7:0] base;
        case (sz)
            2'd0:    base = 8'h01;
            2'd1:    base = 8'h03;
            default: base = 8'h0F;
        endcase
        return base << off;
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/sau_lane_plan.sv
module sau_lane_plan
    import sau_pkg::*;
(
    input  logic [1:0] off,
    input  logic [1:0] sz,
    output lane_plan_t plan
);

    logic [7:0] span;

    always_comb begin
        span       = lane_span(off, sz);
        plan.be_lo = span[3:0];
        plan.be_hi = span[7:4];
        plan.split = |span[7:4];
        case (sz)
            2'd0:    plan.misal = 1'b0;
            2'd1:    plan.misal = off[0];
            default: plan.misal = (off != 2'd0);
        endcase
    end

    always_comb begin
        // R5
        byte_nosplit_chk: assert (!(sz == 2'd0 && plan.split === 1'b1));
        // R6
        split_is_misal_chk: assert (!(plan.split === 1'b1 && plan.misal === 1'b0));
    end

endmodule

// File: rtl/sau_byte_steer.sv
module sau_byte_steer
    import sau_pkg::*;
(
    input  logic [1:0]  off,
    input  logic [1:0]  sz,
    input  logic [31:0] lo_word,
    input  logic [31:0] hi_word,
    input  logic [31:0] wdata,
    output logic [31:0] rd_merged,
    output logic [31:0] wd_lo,
    output logic [31:0] wd_hi
);

    logic [63:0] pair;
    logic [63:0] shifted;
    logic [63:0] wide;
    logic [5:0]  sh;

    always_comb begin
        sh        = {1'b0, off, 3'b000};
        pair      = {hi_word, lo_word};
        shifted   = pair >> sh;
        rd_merged = shifted[31:0] & size_mask(sz);
        wide      = {32'h0, wdata} << sh;
        wd_lo     = wide[31:0];
        wd_hi     = wide[63:32];
    end

endmodule

// File: rtl/sau_mem.sv
module sau_mem #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    output logic [31:0]      q
);

    localparam int ROWS  = 1 << IDX_W;
    localparam int LANES = 4;

    logic [ROWS-1:0] row_sel;
    logic [7:0]      cells [ROWS][LANES];

    genvar r;
    generate
        for (r = 0; r < ROWS; r++) begin : g_row_dec
            assign row_sel[r] = en && (idx == IDX_W'(r));
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int rr = 0; rr < ROWS; rr++) begin
            for (int l = 0; l < LANES; l++) begin
                if (we && be[l] && row_sel[rr]) begin
                    cells[rr][l] <= wdata[8*l +: 8];
                end
            end
        end
        if (en && !we) begin
            for (int l = 0; l < LANES; l++) begin
                q[8*l +: 8] <= cells[idx][l];
            end
        end
    end

    always_comb begin
        if (en === 1'b1) begin
            // R2
            row_onehot_chk: assert ($onehot(row_sel));
        end else if (en === 1'b0) begin
            // R2
            row_quiet_chk: assert (row_sel == '0);
        end
    end

endmodule

// File: rtl/split_access_unit.sv
module split_access_unit
    import sau_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic              err,
    output logic [31:0]       rdata
);

    localparam int IDX_W = ADDR_W - 2;

    sau_state_e       state;
    logic             r_write;
    logic [1:0]       r_off;
    logic [1:0]       r_sz;
    logic [IDX_W-1:0] r_idx;
    logic [31:0]      r_wdata;
    logic [31:0]      hold0;
    logic             done_q;
    logic             err_q;
    logic [31:0]      rdata_q;

    lane_plan_t       in_plan;
    lane_plan_t       cur_plan;

    logic             accept;
    logic             trap_hit;

    logic             mem_en;
    logic             mem_we;
    logic [IDX_W-1:0] mem_idx;
    logic [3:0]       mem_be;
    logic [31:0]      mem_wd;
    logic [31:0]      mem_q;

    logic [31:0]      lo_sel;
    logic [31:0]      rd_merged;
    logic [31:0]      wd_lo;
    logic [31:0]      wd_hi;

    sau_lane_plan u_plan_in (
        .off  (req_addr[1:0]),
        .sz   (req_size),
        .plan (in_plan)
    );

    sau_lane_plan u_plan_cur (
        .off  (r_off),
        .sz   (r_sz),
        .plan (cur_plan)
    );

    assign lo_sel = cur_plan.split ? hold0 : mem_q;

    sau_byte_steer u_steer (
        .off       (r_off),
        .sz        (r_sz),
        .lo_word   (lo_sel),
        .hi_word   (mem_q),
        .wdata     (r_wdata),
        .rd_merged (rd_merged),
        .wd_lo     (wd_lo),
        .wd_hi     (wd_hi)
    );

    always_comb begin
        mem_en  = (state == ST_ACC0) || (state == ST_ACC1);
        mem_we  = mem_en && r_write;
        mem_idx = (state == ST_ACC1) ? r_idx + IDX_W'(1) : r_idx;
        mem_be  = (state == ST_ACC1) ? cur_plan.be_hi : cur_plan.be_lo;
        mem_wd  = (state == ST_ACC1) ? wd_hi : wd_lo;
    end

    sau_mem #(.IDX_W(IDX_W)) u_mem (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .idx   (mem_idx),
        .be    (mem_be),
        .wdata (mem_wd),
        .q     (mem_q)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign trap_hit  = trap_en && in_plan.misal;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            r_write <= 1'b0;
            r_off   <= 2'd0;
            r_sz    <= 2'd0;
            r_idx   <= '0;
            r_wdata <= '0;
            hold0   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (trap_hit) begin
                            err_q <= 1'b1;
                        end else begin
                            r_write <= req_write;
                            r_off   <= req_addr[1:0];
                            r_sz    <= req_size;
                            r_idx   <= req_addr[ADDR_W-1:2];
                            r_wdata <= req_wdata;
                            state   <= ST_ACC0;
                        end
                    end
                end
                ST_ACC0: begin
                    state <= cur_plan.split ? ST_ACC1 : ST_WRAP;
                end
                ST_ACC1: begin
                    hold0 <= mem_q;
                    state <= ST_WRAP;
                end
                default: begin
                    if (!r_write) begin
                        rdata_q <= rd_merged;
                    end
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
            endcase
        end
    end

    assign done  = done_q;
    assign err   = err_q;
    assign rdata = rdata_q;

    // R6
    trap_err_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && trap_en && in_plan.misal) |=> (err && !done && req_ready));

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !(trap_en && in_plan.misal)) |=> !req_ready);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    // R9
    no_done_err_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R5
    split_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !$past(mem_en) && cur_plan.split) |=> mem_en);

endmodule

// File: tb/split_access_unit_tb.sv
module split_access_unit_tb;

    localparam int PERIOD = 10;
    localparam int AW     = 8;
    localparam int NB     = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          trap_en;
    logic          req_valid;
    logic          req_ready;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_size;
    logic [31:0]   req_wdata;
    logic          done;
    logic          err;
    logic [31:0]   rdata;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [NB];

    always #(PERIOD/2) clk = ~clk;

    split_access_unit #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .trap_en   (trap_en),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .done      (done),
        .err       (err),
        .rdata     (rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_read(input int a, input int sz);
        logic [31:0] v = '0;
        for (int i = 0; i < nbytes(sz); i++) v[8*i +: 8] = model[(a + i) % NB];
        return v;
    endfunction

    function automatic bit crosses(input int a, input int sz);
        return ((a % 4) + nbytes(sz)) > 4;
    endfunction

    function automatic bit misaligned(input int a, input int sz);
        return (sz == 1) ? (a % 2 != 0) : (sz == 0) ? 1'b0 : (a % 4 != 0);
    endfunction

    // lat counts rising edges from the accepting one (1) to the one that raised done/err
    task automatic access(input bit wr, input int a, input int sz, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat, output bit e);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_size  = 2'(sz);
        req_wdata = wd;
        @(posedge clk);
        lat = 99;
        e   = 1'b0;
        rd  = '0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done || err) begin
                lat = k;
                e   = err;
                rd  = rdata;
                break;
            end
        end
        @(negedge clk);
        // R9: pulses last one cycle
        check(!done && !err, "R9", {30'd0, done, err}, 32'd0);
    endtask

    task automatic do_write(input int a, input int sz, input logic [31:0] wd);
        logic [31:0] rd;
        int lat;
        bit e;
        access(1'b1, a, sz, wd, rd, lat, e);
        for (int i = 0; i < nbytes(sz); i++) model[(a + i) % NB] = wd[8*i +: 8];
        check(lat == (crosses(a, sz) ? 4 : 3) && !e, crosses(a, sz) ? "R5" : "R2",
              32'(lat), crosses(a, sz) ? 32'd4 : 32'd3);
    endtask

    task automatic do_read_chk(input int a, input int sz, input string req);
        logic [31:0] rd;
        int lat;
        bit e;
        access(1'b0, a, sz, 32'h0, rd, lat, e);
        check(rd == exp_read(a, sz) && !e, req, rd, exp_read(a, sz));
        check(lat == (crosses(a, sz) ? 4 : 3), crosses(a, sz) ? "R5" : "R2",
              32'(lat), crosses(a, sz) ? 32'd4 : 32'd3);
    endtask

    task automatic byte_sweep(input string req);
        for (int a = 0; a < NB; a++) do_read_chk(a, 0, req);
    endtask

    initial begin
        #(PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int lat;
        bit e;

        rst       = 1'b1;
        trap_en   = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_size  = '0;
        req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(req_ready && !done && !err, "R1", {29'd0, req_ready, done, err}, 32'd4);

        // fill memory with aligned word writes
        for (int w = 0; w < NB / 4; w++) begin
            logic [31:0] v;
            for (int i = 0; i < 4; i++) v[8*i +: 8] = 8'((4*w + i) * 7 + 3);
            do_write(4*w, 2, v);
        end
        byte_sweep("R3");

        // reads of every size at every address; top addresses cover wrap (R8)
        for (int a = 0; a < NB; a++) begin
            do_read_chk(a, 1, (a >= NB - 3) ? "R8" : "R3");
            do_read_chk(a, 2, (a >= NB - 3) ? "R8" : "R3");
        end
        do_read_chk(NB - 1, 3, "R8");

        // writes of every size at every address with readback (R4)
        for (int a = 0; a < NB; a++) begin
            for (int sz = 0; sz < 3; sz++) begin
                logic [31:0] wd = 32'(a * 32'h01030507 + sz * 32'h11111111) ^ 32'hA5C3_0F96;
                do_write(a, sz, wd);
                do_read_chk(a, sz, "R4");
            end
        end
        byte_sweep("R4");

        // wrap write at top of memory (R8)
        do_write(NB - 2, 2, 32'hCAFE_F00D);
        do_read_chk(0, 1, "R8");
        do_read_chk(NB - 2, 1, "R8");

        // trap mode
        trap_en = 1'b1;
        for (int a = 0; a < 8; a++) begin
            for (int sz = 0; sz < 3; sz++) begin
                if (misaligned(a, sz)) begin
                    access(1'b1, a, sz, 32'hDEAD_BEEF, rd, lat, e);
                    check(e && lat == 1, "R6", 32'(lat), 32'd1);
                    access(1'b0, a, sz, 32'h0, rd, lat, e);
                    check(e && lat == 1, "R6", {31'd0, e}, 32'd1);
                end else begin
                    do_read_chk(a, sz, "R6");
                end
            end
        end
        // memory untouched by trapped writes
        for (int a = 0; a < 12; a++) do_read_chk(a, 0, "R6");
        trap_en = 1'b0;
        // non-trap, misaligned but in-word half access
        do_read_chk(1, 1, "R2");

        // request held during a split read is ignored (R7)
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = AW'(6);
        req_size  = 2'd2;
        @(posedge clk);
        @(negedge clk);
        req_write = 1'b1;
        req_addr  = AW'(20);
        req_size  = 2'd0;
        req_wdata = 32'h0000_005A ^ {24'd0, model[20]};
        lat = 1;
        while (!done && lat < 20) begin
            check(!req_ready, "R7", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        check(rdata == exp_read(6, 2), "R7", rdata, exp_read(6, 2));
        check(lat == 4, "R7", 32'(lat), 32'd4);
        do_read_chk(20, 0, "R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule